// File: doc/BRIEF.md
# Oscillator Bias Assignment Search

This block chooses a bias setting for each of three noise oscillators from a table of measured entropy scores. The table holds one unsigned score per oscillator per bias setting, four settings each. After a start pulse the block walks every combination of biases. It rejects any combination in which two oscillators share a bias, and keeps the one whose three scores add up to the largest total.

When the walk is over, the block publishes four results: the winning biases packed into one word, the winning total, the three per-oscillator scores of the winner, and a flag that tells whether the total reaches the minimum needed for usable entropy. If the total falls short, the per-oscillator scores are reported as zero. The bias word and the total are still given. The results stay on the outputs until the next search publishes new ones. A one-cycle done pulse marks each publication.

Top module: `bias_search`

## Requirements
- R1: A start pulse seen while idle begins a search. The search visits all 64 bias tuples, one per clock, in nested order with oscillator 0's bias outermost and oscillator 2's innermost. `done` is high for exactly one cycle, 65 clock edges after the edge that sampled `start`. `busy` is high from the edge after start until the edge that raises `done`.
- R2: A tuple in which any two oscillators have the same bias is never chosen. Only the 24 all-distinct tuples compete.
- R3: A tuple's total is the sum of the three table entries it selects. The sum is formed in 66 bits, so three maximal 64-bit scores do not wrap.
- R4: The table entry for oscillator n at bias b sits at bits [(4n+b)*64 +: 64] of `score_tbl`. The bias of oscillator n sits at bits [2n+1:2n] of `bias_word`. The score of oscillator n sits at bits [64n +: 64] of `cell_scores`.
- R5: If no candidate total exceeds zero, the bias word keeps its default: oscillator 0 at bias 0, oscillator 1 at bias 1, oscillator 2 at bias 2, which is 6'h24.
- R6: The kept result is replaced only when a candidate total is strictly greater than the best so far. On a tie, the candidate visited first in the R1 order is the one kept.
- R7: `entropy_ok` is 1 when the winning total is at least 150000000. When it is 0, `cell_scores` is all zeros, while `bias_word` and `total` still report the winner.
- R8: A start pulse during a search is ignored. The results outputs change only in the cycle that `done` rises, and otherwise hold their values.
- R9: After reset, `busy`, `done`, `entropy_ok`, `bias_word`, `total` and `cell_scores` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search when idle |
| score_tbl | input | 768 | Entropy score table, 12 entries of 64 bits |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are published |
| bias_word | output | 6 | Packed winning biases, 2 bits per oscillator |
| total | output | 66 | Winning summed score |
| cell_scores | output | 192 | Per-oscillator scores of the winner, zero on failure |
| entropy_ok | output | 1 | Winning total meets the minimum |

## Verification
The bench builds the block with its default parameters: three oscillators, four biases, 64-bit scores and a 150000000 minimum. With only 64 tuples per search, every search covers the whole space, so a software nested-loop model with the same strict-greater rule gives the exact expected winner. Dozens of pseudo-random tables are scaled so that their totals fall on both sides of the minimum. Directed tables then cover the all-zero default, ties, maxima placed on shared biases, full-scale scores that need the carry bits, and totals exactly at and one below the minimum.

// File: rtl/bias_search_pkg.sv
package bias_search_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WALK    = 2'd1,
    PH_PUBLISH = 2'd2
  } walk_phase_t;
endpackage

// File: rtl/bias_walk.sv
module bias_walk
  import bias_search_pkg::*;
#(
  parameter int NUM_OSC  = 3,
  parameter int NUM_BIAS = 4,
  localparam int BIAS_W  = $clog2(NUM_BIAS),
  localparam int IDX_W   = NUM_OSC * BIAS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic [IDX_W-1:0] tuple_o,
  output logic             distinct_o,
  output logic             eval_o,
  output logic             init_o,
  output logic             publish_o,
  output logic             busy_o
);
  walk_phase_t      phase;
  logic [IDX_W-1:0] idx;
  logic             last;

  assign last      = &idx;
  assign init_o    = start_i && (phase == PH_IDLE);
  assign eval_o    = (phase == PH_WALK);
  assign publish_o = (phase == PH_PUBLISH);
  assign busy_o    = (phase != PH_IDLE);

  // oscillator 0 is the most significant digit of the walk counter
  generate
    for (genvar n = 0; n < NUM_OSC; n++) begin : g_digit
      assign tuple_o[n*BIAS_W +: BIAS_W] = idx[(NUM_OSC-1-n)*BIAS_W +: BIAS_W];
    end
  endgenerate

  always_comb begin
    distinct_o = 1'b1;
    for (int a = 0; a < NUM_OSC; a++) begin
      for (int b = a + 1; b < NUM_OSC; b++) begin
        if (tuple_o[a*BIAS_W +: BIAS_W] == tuple_o[b*BIAS_W +: BIAS_W]) begin
          distinct_o = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start_i) begin
            phase <= PH_WALK;
            idx   <= '0;
          end
        end
        PH_WALK: begin
          idx <= idx + 1'b1;
          if (last) phase <= PH_PUBLISH;
        end
        PH_PUBLISH: phase <= PH_IDLE;
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  // R1: the walk counter advances by one each cycle, even when start arrives mid-walk (R8)
  p_walk_step_r1: assert property (@(posedge clk) disable iff (rst)
    (eval_o && !last) |=> (eval_o && idx == $past(idx) + 1'b1));

  // R1: the last tuple is followed by exactly one publish cycle
  p_walk_end_r1: assert property (@(posedge clk) disable iff (rst)
    (eval_o && last) |=> (publish_o ##1 !busy_o));

  // R8: start during the walk does not restart the counter
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !publish_o && !last) |=> (idx != '0));
endmodule

// File: rtl/cand_scorer.sv
module cand_scorer #(
  parameter int NUM_OSC  = 3,
  parameter int NUM_BIAS = 4,
  parameter int SCORE_W  = 64,
  localparam int BIAS_W  = $clog2(NUM_BIAS),
  localparam int IDX_W   = NUM_OSC * BIAS_W,
  localparam int SUM_W   = SCORE_W + $clog2(NUM_OSC),
  localparam int TBL_W   = NUM_OSC * NUM_BIAS * SCORE_W
) (
  input  logic [TBL_W-1:0]           tbl_i,
  input  logic [IDX_W-1:0]           tuple_i,
  output logic [NUM_OSC*SCORE_W-1:0] cells_o,
  output logic [SUM_W-1:0]           total_o
);
  generate
    for (genvar n = 0; n < NUM_OSC; n++) begin : g_pick
      logic [BIAS_W-1:0] sel;
      assign sel = tuple_i[n*BIAS_W +: BIAS_W];
      always_comb begin
        cells_o[n*SCORE_W +: SCORE_W] = '0;
        for (int b = 0; b < NUM_BIAS; b++) begin
          if (sel == b[BIAS_W-1:0]) begin
            cells_o[n*SCORE_W +: SCORE_W] = tbl_i[(n*NUM_BIAS + b)*SCORE_W +: SCORE_W];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    total_o = '0;
    for (int n = 0; n < NUM_OSC; n++) begin
      total_o = total_o + {{(SUM_W-SCORE_W){1'b0}}, cells_o[n*SCORE_W +: SCORE_W]};
    end
  end
endmodule

// File: rtl/best_keeper.sv
module best_keeper #(
  parameter int NUM_OSC  = 3,
  parameter int NUM_BIAS = 4,
  parameter int SCORE_W  = 64,
  localparam int BIAS_W  = $clog2(NUM_BIAS),
  localparam int IDX_W   = NUM_OSC * BIAS_W,
  localparam int SUM_W   = SCORE_W + $clog2(NUM_OSC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       init_i,
  input  logic                       eval_i,
  input  logic                       distinct_i,
  input  logic [IDX_W-1:0]           cand_word_i,
  input  logic [SUM_W-1:0]           cand_total_i,
  input  logic [NUM_OSC*SCORE_W-1:0] cand_cells_i,
  output logic [IDX_W-1:0]           best_word_o,
  output logic [SUM_W-1:0]           best_total_o,
  output logic [NUM_OSC*SCORE_W-1:0] best_cells_o
);
  logic [IDX_W-1:0] dflt_word;
  logic             better;

  // default assignment: oscillator n at bias n
  generate
    for (genvar n = 0; n < NUM_OSC; n++) begin : g_dflt
      assign dflt_word[n*BIAS_W +: BIAS_W] = BIAS_W'(n);
    end
  endgenerate

  assign better = eval_i && distinct_i && (cand_total_i > best_total_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      best_word_o  <= '0;
      best_total_o <= '0;
      best_cells_o <= '0;
    end else if (init_i) begin
      best_word_o  <= dflt_word;
      best_total_o <= '0;
      best_cells_o <= '0;
    end else if (better) begin
      best_word_o  <= cand_word_i;
      best_total_o <= cand_total_i;
      best_cells_o <= cand_cells_i;
    end
  end

  // R6: the best total never decreases during a walk
  p_best_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !init_i) |=> (best_total_o >= $past(best_total_o)));

  // R6: an equal total never displaces the kept result
  p_tie_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (eval_i && cand_total_i == best_total_o) |=> $stable(best_word_o));

  // R2: a tuple with a repeated bias never enters the kept result
  p_skip_repeat_r2: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !distinct_i) |=> $stable(best_word_o));
endmodule

// File: rtl/bias_search.sv
module bias_search #(
  parameter int NUM_OSC  = 3,
  parameter int NUM_BIAS = 4,
  parameter int SCORE_W  = 64,
  parameter longint unsigned PASS_MIN = 64'd150000000,
  localparam int BIAS_W  = $clog2(NUM_BIAS),
  localparam int IDX_W   = NUM_OSC * BIAS_W,
  localparam int SUM_W   = SCORE_W + $clog2(NUM_OSC),
  localparam int TBL_W   = NUM_OSC * NUM_BIAS * SCORE_W,
  localparam int CELL_W  = NUM_OSC * SCORE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TBL_W-1:0]  score_tbl,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  bias_word,
  output logic [SUM_W-1:0]  total,
  output logic [CELL_W-1:0] cell_scores,
  output logic              entropy_ok
);
  localparam logic [SUM_W-1:0] PASS_MIN_W = SUM_W'(PASS_MIN);

  logic [IDX_W-1:0]  tuple;
  logic              distinct, eval, init, publish;
  logic [CELL_W-1:0] cand_cells, best_cells;
  logic [SUM_W-1:0]  cand_total, best_total;
  logic [IDX_W-1:0]  best_word;
  logic              pass;

  bias_walk #(.NUM_OSC(NUM_OSC), .NUM_BIAS(NUM_BIAS)) u_walk (
    .clk(clk), .rst(rst), .start_i(start),
    .tuple_o(tuple), .distinct_o(distinct), .eval_o(eval),
    .init_o(init), .publish_o(publish), .busy_o(busy)
  );

  cand_scorer #(.NUM_OSC(NUM_OSC), .NUM_BIAS(NUM_BIAS), .SCORE_W(SCORE_W)) u_score (
    .tbl_i(score_tbl), .tuple_i(tuple), .cells_o(cand_cells), .total_o(cand_total)
  );

  best_keeper #(.NUM_OSC(NUM_OSC), .NUM_BIAS(NUM_BIAS), .SCORE_W(SCORE_W)) u_keep (
    .clk(clk), .rst(rst), .init_i(init), .eval_i(eval), .distinct_i(distinct),
    .cand_word_i(tuple), .cand_total_i(cand_total), .cand_cells_i(cand_cells),
    .best_word_o(best_word), .best_total_o(best_total), .best_cells_o(best_cells)
  );

  assign pass = (best_total >= PASS_MIN_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      bias_word   <= '0;
      total       <= '0;
      cell_scores <= '0;
      entropy_ok  <= 1'b0;
    end else begin
      done <= publish;
      if (publish) begin
        bias_word   <= best_word;
        total       <= best_total;
        entropy_ok  <= pass;
        cell_scores <= pass ? best_cells : '0;
      end
    end
  end

  function automatic logic fields_distinct(input logic [IDX_W-1:0] w);
    fields_distinct = 1'b1;
    for (int a = 0; a < NUM_OSC; a++)
      for (int b = a + 1; b < NUM_OSC; b++)
        if (w[a*BIAS_W +: BIAS_W] == w[b*BIAS_W +: BIAS_W]) fields_distinct = 1'b0;
  endfunction

  function automatic logic [SUM_W-1:0] cell_sum(input logic [CELL_W-1:0] c);
    cell_sum = '0;
    for (int n = 0; n < NUM_OSC; n++)
      cell_sum = cell_sum + {{(SUM_W-SCORE_W){1'b0}}, c[n*SCORE_W +: SCORE_W]};
  endfunction

  // R1: done is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: busy falls exactly when done rises
  p_busy_done_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: the published word never repeats a bias
  p_distinct_word_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> fields_distinct(bias_word));

  // R3: on a pass the reported total equals the wide sum of the reported cells
  p_sum_cells_r3: assert property (@(posedge clk) disable iff (rst)
    (done && entropy_ok) |-> (total == cell_sum(cell_scores)));

  // R7: the pass flag agrees with the threshold, and failures clear the cells
  p_pass_flag_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (entropy_ok == (total >= PASS_MIN_W)));
  p_fail_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !entropy_ok) |-> (cell_scores == '0));

  // R8: results hold except in the cycle done rises
  p_hold_results_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(bias_word) && $stable(total) && $stable(entropy_ok)));
endmodule

// File: tb/bias_search_bench.sv
module bias_search_bench;
  localparam int NO = 3;
  localparam int NB = 4;
  localparam int SW = 64;
  localparam longint unsigned MINV = 64'd150000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NO*NB*SW-1:0] tbl_flat;
  logic busy, done, entropy_ok;
  logic [5:0]   bias_word;
  logic [65:0]  total;
  logic [191:0] cell_scores;

  logic [63:0] tbl [NO][NB];
  int checks = 0;
  int fails = 0;
  logic [63:0] rng_state = 64'h9e3779b97f4a7c15;

  always #4 clk = ~clk;

  always_comb begin
    for (int n = 0; n < NO; n++)
      for (int b = 0; b < NB; b++)
        tbl_flat[(n*NB+b)*SW +: SW] = tbl[n][b];
  end

  bias_search u_bias_search (
    .clk(clk), .rst(rst), .start(start), .score_tbl(tbl_flat),
    .busy(busy), .done(done), .bias_word(bias_word), .total(total),
    .cell_scores(cell_scores), .entropy_ok(entropy_ok)
  );

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rnd();
    rng_state = rng_state ^ (rng_state << 13);
    rng_state = rng_state ^ (rng_state >> 7);
    rng_state = rng_state ^ (rng_state << 17);
    return rng_state;
  endfunction

  // reference: nested walk, strict greater, default 0/1/2
  task automatic model(output logic [5:0] ew, output logic [65:0] et,
                       output logic [191:0] ec, output logic eok);
    logic [65:0] s;
    ew = 6'h24; et = '0; ec = '0;
    for (int b0 = 0; b0 < NB; b0++)
      for (int b1 = 0; b1 < NB; b1++)
        for (int b2 = 0; b2 < NB; b2++) begin
          if (b0 == b1 || b0 == b2 || b1 == b2) continue;
          s = 66'(tbl[0][b0]) + 66'(tbl[1][b1]) + 66'(tbl[2][b2]);
          if (s > et) begin
            et = s;
            ew = {2'(b2), 2'(b1), 2'(b0)};
            ec = {tbl[2][b2], tbl[1][b1], tbl[0][b0]};
          end
        end
    eok = (et >= 66'(MINV));
    if (!eok) ec = '0;
  endtask

  task automatic run_search(output int lat);
    lat = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    lat--;
  endtask

  task automatic run_and_check(input string req);
    logic [5:0] ew; logic [65:0] et; logic [191:0] ec; logic eok;
    int lat;
    model(ew, et, ec, eok);
    run_search(lat);
    check("R1", {req, " latency"}, 256'(lat), 256'(65));
    check(req, "bias_word", 256'(bias_word), 256'(ew));
    check(req, "total", 256'(total), 256'(et));
    check(req, "cell_scores", 256'(cell_scores), 256'(ec));
    check(req, "entropy_ok", 256'(entropy_ok), 256'(eok));
  endtask

  task automatic fill(input logic [63:0] v);
    for (int n = 0; n < NO; n++)
      for (int b = 0; b < NB; b++)
        tbl[n][b] = v;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill('0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9", "busy", 256'(busy), 256'(0));
    check("R9", "done", 256'(done), 256'(0));
    check("R9", "outputs", 256'({bias_word, total, entropy_ok}), 256'(0));
    check("R9", "cells", 256'(cell_scores), 256'(0));

    // R5: nothing beats zero, default word 6'h24, failing
    run_and_check("R5");
    check("R5", "default word", 256'(bias_word), 256'(6'h24));

    // R6: all equal, first visited tuple (0,1,2) kept
    fill(64'd90000000);
    run_and_check("R6");
    // R6: tie between (0,1,2) and (0,1,3)
    fill('0); tbl[0][0] = 64'd100000000; tbl[1][1] = 64'd100000000;
    tbl[2][2] = 64'd7; tbl[2][3] = 64'd7;
    run_and_check("R6");
    check("R6", "tie keeps first", 256'(bias_word), 256'(6'h24));

    // R2: largest values on shared bias 3
    fill(64'd1000); tbl[0][3] = 64'd900000000; tbl[1][3] = 64'd800000000;
    tbl[2][3] = 64'd700000000;
    run_and_check("R2");
    // R3: full-scale scores need carry bits
    fill(64'hffff_ffff_ffff_ffff);
    run_and_check("R3");
    check("R3", "wide total", 256'(total), 256'(66'h2_ffff_ffff_ffff_fffd));

    // R7: exactly at and one below the minimum
    fill('0); tbl[0][0] = MINV;
    run_and_check("R7");
    check("R7", "at minimum passes", 256'(entropy_ok), 256'(1));
    tbl[0][0] = MINV - 1;
    run_and_check("R7");
    check("R7", "below minimum cells cleared", 256'(cell_scores), 256'(0));

    // R4: distinct single hot entries reveal field placement
    fill('0); tbl[0][2] = 64'd300000000; tbl[1][0] = 64'd200000000; tbl[2][3] = 64'd100000000;
    run_and_check("R4");
    check("R4", "packed word", 256'(bias_word), 256'({2'd3, 2'd0, 2'd2}));

    // R2 R3 R6 R7: pseudo-random sweeps around the threshold
    for (int k = 0; k < 40; k++) begin
      for (int n = 0; n < NO; n++)
        for (int b = 0; b < NB; b++)
          tbl[n][b] = next_rnd() >> (36 + (k % 8));
      if (k % 5 == 0) tbl[k % 3][k % 4] = tbl[(k+1) % 3][k % 4];
      run_and_check("R2_R3_R6_R7");
    end

    // R8: start during a search is ignored, results hold afterwards
    begin
      logic [5:0] ew; logic [65:0] et; logic [191:0] ec; logic eok;
      int lat;
      fill('0); tbl[0][1] = 64'd400000000; tbl[1][2] = 64'd5; tbl[2][0] = 64'd9;
      model(ew, et, ec, eok);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      lat = 1;
      repeat (10) @(negedge clk);
      lat += 10;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      lat++;
      while (!done && lat < 200) begin
        @(negedge clk);
        lat++;
      end
      lat--;
      check("R8", "latency with mid-walk start", 256'(lat), 256'(65));
      check("R8", "word", 256'(bias_word), 256'(ew));
      fill(64'd999999999);
      repeat (20) @(negedge clk);
      check("R8", "held word", 256'(bias_word), 256'(ew));
      check("R8", "held total", 256'(total), 256'(et));
      check("R8", "idle after one search", 256'({busy, done}), 256'(0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule